// File: doc/BRIEF.md
# PLL Dynamic Phase Shift Sequencer

This block sits in the phase-shift clock domain, in front of the dynamic phase shift port of a PLL. A user asks for a phase move by giving three things: which output counter to move, which way to move it, and a total number of steps. Each step is one eighth of the VCO period. The PLL port can take at most seven steps per operation and must never be started with a step count of zero. The block therefore breaks the request into as many operations as it needs. Every full operation carries seven steps, and a last, shorter operation carries whatever remains.

For each operation the block raises the start strobe for a single cycle. It holds the counter select, direction and step count steady until the PLL answers with its one-cycle completion pulse. It then waits out the mandatory gap of four clock cycles before it starts the next operation. The user sees `busy` while a request is in progress and a single-cycle `done` when the request is finished. A request for zero steps finishes at once and issues no operation.

Top module: `phase_step_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, and in the cycle that follows, `busy`, `done` and `phaseEn` are 0 and `phaseSteps` is 0.
- R2: When a request with `reqCount` > 0 is accepted (`reqValid` high at an edge while `busy` is low), `phaseEn` is high for exactly one cycle in the very next cycle, and `busy` is high from that cycle on.
- R3: A request for N steps produces ceil(N/7) operations. Every operation except the last carries 7 steps in `phaseSteps`, and the last carries N - 7*(ceil(N/7)-1) steps.
- R4: `phaseSteps` is never 0 in a cycle where `phaseEn` is high.
- R5: `phaseSel` equals the requested 5-bit counter select and `phaseDir` equals the requested direction (1 = positive shift, 0 = negative shift). Both, together with `phaseSteps`, stay unchanged from the strobe cycle until the completion pulse arrives.
- R6: If phaseDone is high in cycle t, the next strobe of the same request occurs in cycle t+4, neither earlier nor later.
- R7: After the completion of the final operation in cycle t, `done` is high in cycle t+4 for exactly one cycle, and `busy` is low in that same cycle.
- R8: An accepted request with `reqCount` = 0 raises `done` in the next cycle, keeps `busy` low and issues no strobe.
- R9: `reqValid` is ignored while `busy` is high. It adds no operation and changes no select, direction or step value.
- R10: While an operation is waiting for `phaseDone`, no new strobe is issued, however long the wait lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-shift clock (100 MHz or slower) |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Single-cycle request; taken only while idle |
| reqSel | input | SEL_W (5) | Counter to be shifted |
| reqDir | input | 1 | Requested direction, 1 positive, 0 negative |
| reqCount | input | TOTAL_W (8) | Total number of 1/8-VCO-period steps |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse when a request has finished |
| phaseEn | output | 1 | One-cycle start strobe to the PLL |
| phaseDir | output | 1 | Direction presented to the PLL |
| phaseSel | output | SEL_W (5) | Counter select presented to the PLL |
| phaseSteps | output | STEP_W (3) | Steps in the current operation |
| phaseDone | input | 1 | One-cycle completion pulse from the PLL |

## Verification
The bench uses the default parameters: TOTAL_W = 8, SEL_W = 5, STEP_W = 3 and HOLDOFF = 4. With these values the full count range up to 255 steps is exercised, which means up to 37 operations in a single request. This range includes the 7 and 8 boundary, exact multiples of seven, and the remainder-of-three tail. A behavioural responder varies the completion latency from one cycle to many. This shows that the four-cycle gap counts from the completion pulse and not from the strobe.

// File: rtl/pss_pkg.sv
package pss_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_HOLD
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture a new request
    logic issue;    // current operation is being started
    logic advance;  // prepare the next operation's step count
  } dpCmd_t;

endpackage

// File: rtl/pss_datapath.sv
module pss_datapath
  import pss_pkg::*;
#(
  parameter int TOTAL_W = 8,
  parameter int SEL_W   = 5,
  parameter int STEP_W  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  dpCmd_t             cmd,
  input  logic [SEL_W-1:0]   reqSel,
  input  logic               reqDir,
  input  logic [TOTAL_W-1:0] reqCount,
  output logic [SEL_W-1:0]   opSel,
  output logic               opDir,
  output logic [STEP_W-1:0]  opSteps,
  output logic               lastOp,
  output logic               reqZero
);

  localparam int MAX_STEP_I = (1 << STEP_W) - 1;
  localparam logic [TOTAL_W-1:0] MAX_STEP_T = TOTAL_W'(MAX_STEP_I);
  localparam logic [STEP_W-1:0]  MAX_STEP_S = STEP_W'(MAX_STEP_I);

  logic [TOTAL_W-1:0] remaining;
  logic [STEP_W-1:0]  stepReg;
  logic [SEL_W-1:0]   selReg;
  logic               dirReg;

  function automatic logic [STEP_W-1:0] clampStep(input logic [TOTAL_W-1:0] v);
    if (v > MAX_STEP_T) return MAX_STEP_S;
    else                return v[STEP_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      remaining <= '0;
      stepReg   <= '0;
      selReg    <= '0;
      dirReg    <= 1'b0;
    end else begin
      if (cmd.load) begin
        remaining <= reqCount;
        stepReg   <= clampStep(reqCount);
        selReg    <= reqSel;
        dirReg    <= reqDir;
      end else if (cmd.issue) begin
        remaining <= remaining - TOTAL_W'(stepReg);
      end else if (cmd.advance) begin
        stepReg   <= clampStep(remaining);
      end
    end
  end

  assign opSel   = selReg;
  assign opDir   = dirReg;
  assign opSteps = stepReg;
  assign lastOp  = (remaining == '0);
  assign reqZero = (reqCount == '0);

  // R4
  steps_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    cmd.issue |-> stepReg != '0);

  // R3
  short_op_last_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd.issue && stepReg != MAX_STEP_S) |=> remaining == '0);

endmodule

// File: rtl/pss_ctrl.sv
module pss_ctrl
  import pss_pkg::*;
#(
  parameter int HOLDOFF = 4
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   reqValid,
  input  logic   reqZero,
  input  logic   lastOp,
  input  logic   phaseDone,
  output dpCmd_t cmd,
  output logic   phaseEn,
  output logic   busy,
  output logic   done,
  output logic   waiting
);

  localparam int HC_W = (HOLDOFF > 2) ? $clog2(HOLDOFF) : 1;
  localparam logic [HC_W-1:0] HOLD_LAST = HC_W'(HOLDOFF - 2);
  localparam int SD_W = $clog2(HOLDOFF + 1);
  localparam logic [SD_W-1:0] SD_MAX = SD_W'(HOLDOFF);

  seqState_t state, stateNext;
  logic [HC_W-1:0] holdCnt;
  logic doneSet;

  always_comb begin
    stateNext = state;
    cmd       = '0;
    doneSet   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          cmd.load = 1'b1;
          if (reqZero) doneSet = 1'b1;
          else         stateNext = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        cmd.issue = 1'b1;
        stateNext = ST_WAIT;
      end
      ST_WAIT: begin
        if (phaseDone) stateNext = ST_HOLD;
      end
      ST_HOLD: begin
        if (holdCnt == HOLD_LAST) begin
          if (lastOp) begin
            doneSet   = 1'b1;
            stateNext = ST_IDLE;
          end else begin
            cmd.advance = 1'b1;
            stateNext   = ST_ISSUE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      holdCnt <= '0;
      done    <= 1'b0;
    end else begin
      state   <= stateNext;
      done    <= doneSet;
      holdCnt <= (state == ST_HOLD) ? holdCnt + 1'b1 : '0;
    end
  end

  assign phaseEn = (state == ST_ISSUE);
  assign busy    = (state != ST_IDLE);
  assign waiting = (state == ST_WAIT);

  // checker state: cycles since the last completion pulse, saturating
  logic [SD_W-1:0] sinceDone;
  always_ff @(posedge clk) begin
    if (rst)                  sinceDone <= SD_MAX;
    else if (phaseDone)       sinceDone <= SD_W'(1);
    else if (sinceDone != SD_MAX) sinceDone <= sinceDone + 1'b1;
  end

  // R6
  holdoff_gap_chk: assert property (@(posedge clk) disable iff (rst)
    phaseEn |-> sinceDone >= SD_MAX);

  // R2
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    phaseEn |=> !phaseEn);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && reqValid && !phaseEn && !waiting && holdCnt != HOLD_LAST) |=> busy);

endmodule

// File: rtl/phase_step_sequencer.sv
module phase_step_sequencer
  import pss_pkg::*;
#(
  parameter int TOTAL_W = 8,
  parameter int SEL_W   = 5,
  parameter int STEP_W  = 3,
  parameter int HOLDOFF = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reqValid,
  input  logic [SEL_W-1:0]   reqSel,
  input  logic               reqDir,
  input  logic [TOTAL_W-1:0] reqCount,
  output logic               busy,
  output logic               done,
  output logic               phaseEn,
  output logic               phaseDir,
  output logic [SEL_W-1:0]   phaseSel,
  output logic [STEP_W-1:0]  phaseSteps,
  input  logic               phaseDone
);

  dpCmd_t cmd;
  logic   lastOp;
  logic   reqZero;
  logic   waiting;

  pss_ctrl #(.HOLDOFF(HOLDOFF)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .reqValid  (reqValid),
    .reqZero   (reqZero),
    .lastOp    (lastOp),
    .phaseDone (phaseDone),
    .cmd       (cmd),
    .phaseEn   (phaseEn),
    .busy      (busy),
    .done      (done),
    .waiting   (waiting)
  );

  pss_datapath #(
    .TOTAL_W (TOTAL_W),
    .SEL_W   (SEL_W),
    .STEP_W  (STEP_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .cmd      (cmd),
    .reqSel   (reqSel),
    .reqDir   (reqDir),
    .reqCount (reqCount),
    .opSel    (phaseSel),
    .opDir    (phaseDir),
    .opSteps  (phaseSteps),
    .lastOp   (lastOp),
    .reqZero  (reqZero)
  );

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (waiting && !phaseDone) |=> ($stable(phaseSel) && $stable(phaseDir) && $stable(phaseSteps)));

  // R8
  zero_req_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !busy && reqCount == '0) |=> (done && !busy && !phaseEn));

endmodule

// File: tb/sim_phase_step_sequencer.sv
module sim_phase_step_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int TOTAL_W = 8;
  localparam int SEL_W   = 5;
  localparam int STEP_W  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0;
  logic [SEL_W-1:0] reqSel = '0;
  logic reqDir = 1'b0;
  logic [TOTAL_W-1:0] reqCount = '0;
  logic busy, done, phaseEn, phaseDir;
  logic [SEL_W-1:0] phaseSel;
  logic [STEP_W-1:0] phaseSteps;
  logic phaseDone = 1'b0;

  phase_step_sequencer u0 (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqSel(reqSel), .reqDir(reqDir),
    .reqCount(reqCount), .busy(busy), .done(done), .phaseEn(phaseEn),
    .phaseDir(phaseDir), .phaseSel(phaseSel), .phaseSteps(phaseSteps),
    .phaseDone(phaseDone)
  );

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic              dir;
    logic [STEP_W-1:0] steps;
    logic              first;
  } opItem_t;

  opItem_t opQ[$];
  bit      doneQ[$];
  int checks = 0, fails = 0;
  int cyc = 0, lastDone = -100, acceptCyc = 0;
  int respLat = 2;
  bit inOp = 0;
  opItem_t cur;

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    if (phaseDone) begin
      lastDone <= cyc;
      inOp <= 1'b0;
    end
    cyc <= cyc + 1;
  end

  // behavioural completion responder
  initial begin
    forever begin
      @(negedge clk);
      if (phaseEn && !rst) begin
        repeat (respLat) @(negedge clk);
        phaseDone = 1'b1;
        @(negedge clk);
        phaseDone = 1'b0;
      end
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (phaseEn) begin
        check(!inOp, "R10", "strobe while waiting", 1, 0);
        if (opQ.size() == 0) begin
          check(0, "R9", "unexpected strobe", 1, 0);
        end else begin
          opItem_t e;
          e = opQ.pop_front();
          check(phaseSel == e.sel, "R5", "counter select", phaseSel, e.sel);
          check(phaseDir == e.dir, "R5", "direction", phaseDir, e.dir);
          check(phaseSteps == e.steps, "R3", "step count", phaseSteps, e.steps);
          check(phaseSteps != 0, "R4", "zero-step strobe", phaseSteps, 1);
          if (e.first) check(cyc == acceptCyc + 1, "R2", "first strobe cycle", cyc, acceptCyc + 1);
          else         check(cyc - lastDone == 4, "R6", "holdoff gap", cyc - lastDone, 4);
        end
        cur = {phaseSel, phaseDir, phaseSteps, 1'b0};
        inOp = 1'b1;
      end else if (inOp) begin
        check(phaseSel == cur.sel && phaseDir == cur.dir && phaseSteps == cur.steps,
              "R5", "stable while waiting", {phaseSel, phaseDir, phaseSteps},
              {cur.sel, cur.dir, cur.steps});
      end
      if (done) begin
        if (doneQ.size() == 0) begin
          check(0, "R7", "unexpected done", 1, 0);
        end else begin
          bit z;
          z = doneQ.pop_front();
          check(opQ.size() == 0, "R3", "ops left at done", opQ.size(), 0);
          check(!busy, "R7", "busy at done", busy, 0);
          if (!z) check(cyc - lastDone == 4, "R7", "done after holdoff", cyc - lastDone, 4);
        end
      end
    end
  end

  task automatic request(input logic [SEL_W-1:0] sel, input logic dir, input int n);
    int r;
    bit first;
    while (busy || doneQ.size() != 0) @(negedge clk);
    r = n;
    first = 1;
    while (r > 0) begin
      int s;
      s = (r > 7) ? 7 : r;
      opQ.push_back({sel, dir, STEP_W'(s), first});
      r -= s;
      first = 0;
    end
    doneQ.push_back(n == 0);
    reqValid = 1'b1;
    reqSel = sel;
    reqDir = dir;
    reqCount = TOTAL_W'(n);
    acceptCyc = cyc;
    @(negedge clk);
    reqValid = 1'b0;
    if (n == 0) begin
      check(done && !phaseEn, "R8", "zero request done/no strobe", {done, phaseEn}, 2'b10);
      check(!busy, "R8", "zero request busy", busy, 0);
    end else begin
      check(busy, "R2", "busy after accept", busy, 1);
    end
  endtask

  task automatic pokeWhileBusy(input logic [SEL_W-1:0] sel, input logic dir, input int n);
    while (!busy) @(negedge clk);
    repeat (2) @(negedge clk);
    reqValid = 1'b1;
    reqSel = sel;
    reqDir = dir;
    reqCount = TOTAL_W'(n);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy || doneQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(!busy && !done && !phaseEn && phaseSteps == 0, "R1", "outputs in reset",
          {busy, done, phaseEn, phaseSteps}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !phaseEn, "R1", "outputs after reset", {busy, done, phaseEn}, 0);

    respLat = 2;  request(5'd3, 1'b1, 5);   waitIdle();
    respLat = 1;  request(5'd17, 1'b0, 7);  waitIdle();
    request(5'd2, 1'b1, 8);                 waitIdle();
    respLat = 5;  request(5'd9, 1'b0, 14);  waitIdle();
    respLat = 25;
    fork
      request(5'd30, 1'b1, 20);
      pokeWhileBusy(5'd1, 1'b0, 3);
    join
    waitIdle();
    request(5'd4, 1'b0, 0);                 waitIdle();
    respLat = 1;  request(5'd31, 1'b1, 255); waitIdle();
    respLat = 3;  request(5'd0, 1'b0, 1);   waitIdle();
    request(5'd12, 1'b1, 0);                waitIdle();

    repeat (10) @(negedge clk);
    // R9
    check(opQ.size() == 0 && doneQ.size() == 0, "R9", "scoreboard drained",
          opQ.size() + doneQ.size(), 0);
    check(!busy && !phaseEn, "R9", "idle at end", {busy, phaseEn}, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "R10", "watchdog expired", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule